// File: doc/BRIEF.md
# Receive Character Idle Time-Out Detector

This block watches a UART receive FIFO and raises a flag when characters have been waiting in it with no activity for too long. Software can then drain a partly filled FIFO that would otherwise never reach its fill threshold. Any activity restarts the idle window. Activity means either a host read of the receive holding register or a new character arriving. A new character's strobe is timed to the middle of its first stop bit, so the window is measured from that point.

The window is four character times long. The caller supplies one character time as a count of baud ticks, and that count must already include the start, data, parity and stop bits. The block counts baud ticks while it is armed. It is armed only when FIFO mode is on and the FIFO holds data. When the count reaches four times the character time, the flag rises. The flag stays set until the host reads or the block is disarmed. A parameter chooses whether the four-times limit is registered or taken combinationally.

Top module: `rx_char_timeout`

## Requirements
- R1: After reset `timeout_o` is low.
- R2: The block is armed only while `fifo_mode_i` and `fifo_nonempty_i` are both high. While it is disarmed, the idle count is held at zero and `timeout_o` is low.
- R3: While armed, only cycles with `baud_tick_i` high advance the idle count. `timeout_o` rises at the clock edge that accepts the 4·P-th such tick since the last restart, where P is `char_period_i`.
- R4: A cycle with `host_rd_i` high clears `timeout_o` at that edge and restarts the count from zero. This holds even when a baud tick arrives in the same cycle.
- R5: A cycle with `char_wr_i` high restarts the count from zero and leaves `timeout_o` unchanged.
- R6: Once set, `timeout_o` stays high while the block remains armed and no read occurs. Further ticks do not change it.
- R7: If the FIFO empties or FIFO mode turns off, `timeout_o` clears at that edge. When the block is armed again, the count starts again from zero.
- R8: The limit follows `char_period_i` as exactly 4·P ticks. When REG_LIMIT=1, a new period takes effect one cycle after it is applied.
- R9: A period of zero never raises `timeout_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode_i | input | 1 | FIFO mode enable |
| fifo_nonempty_i | input | 1 | Receive FIFO holds at least one character |
| baud_tick_i | input | 1 | One-cycle baud tick strobe |
| char_wr_i | input | 1 | New character written to FIFO (centre of first stop bit) |
| host_rd_i | input | 1 | Host read of the receive holding register |
| char_period_i | input | CHAR_W | One character time in baud ticks |
| timeout_o | output | 1 | Idle time-out event flag |

## Verification
The assertions check, on every cycle, the rules that relate inputs to the flag one edge later:
- A read or a disarm leaves the flag low.
- A character write never clears a set flag.
- The flag rises only on a tick cycle.
- A steady zero period keeps the flag low.

Only the bench scenarios can show that the flag rises exactly on the 4·P-th tick. The same applies to a restart in the middle of a window giving a full new window, to no-tick cycles not counting, and to a changed period moving the rise point.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

   // Four character times expressed in baud ticks (shift by two).
   function automatic logic [25:0] quad_period(input logic [23:0] period);
      return {period, 2'b00};
   endfunction

endpackage

// File: rtl/rxto_limit.sv
module rxto_limit #(
   parameter int CHAR_W    = 12,
   parameter bit REG_LIMIT = 1'b1,
   localparam int CNT_W    = CHAR_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CHAR_W-1:0] period_i,
   output logic [CNT_W-1:0]  limit_o
);
   import rxto_pkg::*;

   logic [25:0]      wide_period_q4;
   logic [CNT_W-1:0] limit_next;

   always_comb begin
      wide_period_q4 = quad_period(24'(period_i));
      limit_next     = wide_period_q4[CNT_W-1:0];
   end

   generate
      if (REG_LIMIT) begin : g_reg
         logic [CNT_W-1:0] limit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) limit_q <= '0;
            else        limit_q <= limit_next;
         end
         assign limit_o = limit_q;
      end else begin : g_comb
         assign limit_o = limit_next;
      end
   endgenerate

endmodule

// File: rtl/rxto_counter.sv
module rxto_counter #(
   parameter int CNT_W = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic             restart_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] idle_cnt;
   logic             below_limit;
   logic             last_step;

   assign below_limit = idle_cnt < limit_i;
   assign last_step   = (idle_cnt + ONE) == limit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        idle_cnt <= '0;
      else if (!arm_i || restart_i)      idle_cnt <= '0;
      else if (tick_i && below_limit)    idle_cnt <= idle_cnt + ONE;
   end

   assign expire_o = arm_i && !restart_i && tick_i && below_limit && last_step;

endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic clear_i,
   input  logic expire_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flag_o <= 1'b0;
      else if (!arm_i || clear_i) flag_o <= 1'b0;
      else if (expire_i)          flag_o <= 1'b1;
   end
endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout #(
   parameter int CHAR_W    = 12,
   parameter bit REG_LIMIT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_mode_i,
   input  logic              fifo_nonempty_i,
   input  logic              baud_tick_i,
   input  logic              char_wr_i,
   input  logic              host_rd_i,
   input  logic [CHAR_W-1:0] char_period_i,
   output logic              timeout_o
);
   localparam int CNT_W = CHAR_W + 2;

   generate
      if (CHAR_W < 2 || CHAR_W > 24) begin : g_bad_width
         $error("rx_char_timeout: CHAR_W must lie in 2..24");
      end
   endgenerate

   logic             armed;
   logic             restart;
   logic             expire;
   logic [CNT_W-1:0] limit;

   assign armed   = fifo_mode_i && fifo_nonempty_i;
   assign restart = host_rd_i || char_wr_i;

   rxto_limit #(.CHAR_W(CHAR_W), .REG_LIMIT(REG_LIMIT)) u_limit (
      .clk      (clk),
      .rst_n    (rst_n),
      .period_i (char_period_i),
      .limit_o  (limit)
   );

   rxto_counter #(.CNT_W(CNT_W)) u_counter (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (armed),
      .restart_i (restart),
      .tick_i    (baud_tick_i),
      .limit_i   (limit),
      .expire_o  (expire)
   );

   rxto_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (armed),
      .clear_i  (host_rd_i),
      .expire_i (expire),
      .flag_o   (timeout_o)
   );

endmodule

// File: rtl/rx_char_timeout_chk.sv
module rx_char_timeout_chk #(
   parameter int CHAR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fifo_mode_i,
   input logic              fifo_nonempty_i,
   input logic              baud_tick_i,
   input logic              char_wr_i,
   input logic              host_rd_i,
   input logic [CHAR_W-1:0] char_period_i,
   input logic              timeout_o
);
   AST_DISARM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_mode_i && fifo_nonempty_i) |=> !timeout_o);                  // R2
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd_i |=> !timeout_o);                                           // R4
   AST_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_o && char_wr_i && !host_rd_i && fifo_mode_i && fifo_nonempty_i) |=> timeout_o); // R5
   AST_HOLD_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_o && !host_rd_i && fifo_mode_i && fifo_nonempty_i) |=> timeout_o); // R6
   AST_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(timeout_o) |-> $past(baud_tick_i));                            // R3
   AST_ZERO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
      (char_period_i == '0 && $stable(char_period_i) && !timeout_o) |=> !timeout_o); // R9
endmodule

bind rx_char_timeout rx_char_timeout_chk #(.CHAR_W(CHAR_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .fifo_mode_i     (fifo_mode_i),
   .fifo_nonempty_i (fifo_nonempty_i),
   .baud_tick_i     (baud_tick_i),
   .char_wr_i       (char_wr_i),
   .host_rd_i       (host_rd_i),
   .char_period_i   (char_period_i),
   .timeout_o       (timeout_o)
);

// File: tb/rx_char_timeout_tb.sv
module rx_char_timeout_tb;
   localparam int CHAR_W = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fifo_mode_i = 1'b0;
   logic              fifo_nonempty_i = 1'b0;
   logic              baud_tick_i = 1'b0;
   logic              char_wr_i = 1'b0;
   logic              host_rd_i = 1'b0;
   logic [CHAR_W-1:0] char_period_i = '0;
   logic              timeout_o;

   int    n_tests = 0;
   int    n_fail  = 0;
   int    cycles  = 0;
   bit    done    = 1'b0;
   logic  exp_q[$];
   string req_q[$];

   always #4 clk = ~clk;

   rx_char_timeout #(.CHAR_W(CHAR_W), .REG_LIMIT(1'b1)) u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .fifo_mode_i     (fifo_mode_i),
      .fifo_nonempty_i (fifo_nonempty_i),
      .baud_tick_i     (baud_tick_i),
      .char_wr_i       (char_wr_i),
      .host_rd_i       (host_rd_i),
      .char_period_i   (char_period_i),
      .timeout_o       (timeout_o)
   );

   // Monitor: pops the expected flag value and compares it away from the edge.
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         logic  e;
         string r;
         e = exp_q.pop_front();
         r = req_q.pop_front();
         n_tests++;
         if (timeout_o !== e) begin
            n_fail++;
            $display("FAIL %s: timeout_o=%b expected %b at t=%0t", r, timeout_o, e, $time);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // Driver: apply one cycle of inputs, queue the flag value expected after the edge.
   task automatic cyc(input bit m, input bit ne, input bit tk, input bit wr,
                      input bit rd, input logic e, input string req);
      fifo_mode_i = m; fifo_nonempty_i = ne; baud_tick_i = tk;
      char_wr_i = wr; host_rd_i = rd;
      @(posedge clk);
      #1;
      exp_q.push_back(e);
      req_q.push_back(req);
      @(negedge clk);
   endtask

   // n armed tick cycles; flag expected high from the rise_at-th tick on.
   task automatic ticks(input int n, input int rise_at, input string req);
      for (int i = 1; i <= n; i++)
         cyc(1, 1, 1, 0, 0, (rise_at > 0 && i >= rise_at), req);
   endtask

   initial begin
      char_period_i = 12'd3;                       // limit 12 ticks
      repeat (3) @(negedge clk);
      n_tests++;
      if (timeout_o !== 1'b0) begin
         n_fail++;
         $display("FAIL R1: timeout_o=%b expected 0", timeout_o);
      end
      rst_n = 1'b1;
      @(negedge clk);
      cyc(0, 0, 0, 0, 0, 1'b0, "R1");

      // R3: window of 12 ticks from a received character.
      cyc(1, 1, 0, 1, 0, 1'b0, "R3");
      ticks(11, 0, "R3");
      cyc(1, 1, 1, 0, 0, 1'b1, "R3");
      // R6: stays set with more ticks and idle cycles.
      ticks(5, 1, "R6");
      cyc(1, 1, 0, 0, 0, 1'b1, "R6");
      // R5: write while set keeps the flag.
      cyc(1, 1, 1, 1, 0, 1'b1, "R5");
      // R4: read with tick in the same cycle clears and restarts.
      cyc(1, 1, 1, 0, 1, 1'b0, "R4");
      ticks(11, 0, "R4");
      cyc(1, 1, 1, 0, 0, 1'b1, "R4");

      // R5: write mid-window restarts the full window.
      cyc(1, 1, 1, 0, 1, 1'b0, "R5");
      ticks(8, 0, "R5");
      cyc(1, 1, 1, 1, 0, 1'b0, "R5");
      ticks(11, 0, "R5");
      cyc(1, 1, 1, 0, 0, 1'b1, "R5");

      // R7: FIFO empties -> flag clears, count held.
      cyc(1, 0, 1, 0, 0, 1'b0, "R7");
      for (int i = 0; i < 20; i++) cyc(1, 0, 1, 0, 0, 1'b0, "R7");
      ticks(11, 0, "R7");
      cyc(1, 1, 1, 0, 0, 1'b1, "R7");
      // R2: FIFO mode off -> no event.
      cyc(0, 1, 1, 0, 0, 1'b0, "R2");
      for (int i = 0; i < 20; i++) cyc(0, 1, 1, 0, 0, 1'b0, "R2");

      // R3: sparse ticks; only tick cycles count.
      cyc(1, 1, 0, 1, 0, 1'b0, "R3");
      for (int i = 1; i <= 12; i++) begin
         cyc(1, 1, 0, 0, 0, 1'b0, "R3");
         cyc(1, 1, 1, 0, 0, (i == 12), "R3");
      end

      // R8: period 1 -> limit 4 ticks; new period applied one cycle ahead.
      cyc(0, 0, 0, 0, 0, 1'b0, "R8");
      char_period_i = 12'd1;
      cyc(0, 0, 0, 0, 0, 1'b0, "R8");
      ticks(3, 0, "R8");
      cyc(1, 1, 1, 0, 0, 1'b1, "R8");
      // R8: period 5 -> limit 20 ticks.
      cyc(0, 0, 0, 0, 0, 1'b0, "R8");
      char_period_i = 12'd5;
      cyc(0, 0, 0, 0, 0, 1'b0, "R8");
      ticks(20, 20, "R8");

      // R9: period zero never fires.
      cyc(0, 0, 0, 0, 0, 1'b0, "R9");
      char_period_i = 12'd0;
      cyc(0, 0, 0, 0, 0, 1'b0, "R9");
      ticks(40, 0, "R9");

      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule